// File: doc/BRIEF.md
# Watchdog Down-Counter with Byte Register Access

This block is a watchdog for a small controller. Software reaches it through a byte-wide write bus with a combinational read-back. A write of any value to the start address loads the down-counter from static option inputs and sets it running. Software keeps the system alive by writing a two-byte key to the refresh address. The key is 00h followed directly by FFh, and it reloads the counter. If the counter passes zero before a valid key arrives, the block either pulses an interrupt and reloads, or drives a reset pulse of fixed length and stops.

One sticky bit in the mode register selects between interrupt and reset. Software can only set this bit, and only while a separate protect-enable input allows mode writes. An external count-source-protection input forces the bit to 1. The other bits of the mode register read as 0.

The register map is fixed by parameters. The defaults place the mode register at address 0, the refresh register at address 1 and the start register at address 2, with the mode bit at bit 3.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, both `wdt_irq_o` and `wdt_rst_o` are low, the mode register (address 0) reads 00h, and the counter does not run until a start write.
- R2: A write of any data value to address 2 loads the counter with `opt_reload_i` (value R) and starts it. In interrupt mode, `wdt_irq_o` is high for exactly one cycle, R+1 clock edges after the edge that captured the write, and this repeats every R+1 edges.
- R3: While the counter runs, a write of 00h to address 1 followed by a write of FFh to address 1 reloads the counter from `opt_reload_i` at the FFh edge. Repeated 00h writes keep the key armed.
- R4: An FFh write to address 1 does not reload the counter unless the previous write to address 1 was 00h. A refresh write of any other value disarms a pending 00h.
- R5: Refresh writes made while the counter is stopped have no effect, and no underflow follows them.
- R6: The mode bit is bit 3 of address 0. While `wp_en_i` is 1, writing 1 to bit 3 sets it. Writing 0 never clears it. Bits 7..4 and 2..0 always read 0.
- R7: While `wp_en_i` is 0, writes to address 0 leave the mode bit unchanged.
- R8: While `cs_force_i` is 1, the mode bit reads 1. It stays 1 after `cs_force_i` returns to 0.
- R9: In reset mode, an underflow drives `wdt_rst_o` high for exactly RST_CYC cycles, starting one edge later than an interrupt would start. The counter then stays stopped until the next start write.
- R10: `wdt_irq_o` is never high for two cycles in a row, never follows an underflow taken in reset mode, and is never high together with `wdt_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (mode register, or 0 for other addresses) |
| wp_en_i | input | 1 | Protect enable; mode writes pass only while 1 |
| cs_force_i | input | 1 | Count-source protection; forces the mode bit to 1 |
| opt_reload_i | input | CNT_W | Static option value used for load and reload |
| wdt_irq_o | output | 1 | Underflow interrupt pulse |
| wdt_rst_o | output | 1 | Underflow reset pulse |

## Verification
The refresh sequence is tried with four key patterns: a clean 00h-FFh pair, a lone FFh, 00h followed by another value and then FFh, and a doubled 00h before FFh. The cycle of the next underflow shows whether the counter was reloaded at the last write or kept counting from the previous reload. Start writes are tried with several data values, both from the stopped state and while running, which shows that the data byte plays no part. Underflow is observed in both modes, with the mode set either by a protected write or by the force input, so interrupt pulses, reset pulse length and the stop after a reset can each be told apart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned BUS_W = 8;
   localparam logic [BUS_W-1:0] KEY_ARM  = 8'h00;
   localparam logic [BUS_W-1:0] KEY_FIRE = 8'hFF;

   typedef struct packed {
      logic start;
      logic reload;
      logic mode_rst;
   } wdog_ctl_t;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned MODE_BIT     = 3,
   parameter int unsigned ADDR_MODE    = 0,
   parameter int unsigned ADDR_REFRESH = 1,
   parameter int unsigned ADDR_START   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              wp_en_i,
   input  logic              cs_force_i,
   input  logic              running_i,
   output wdog_ctl_t         ctl_o,
   output logic [BUS_W-1:0]  bus_rdata
);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
   localparam logic [ADDR_W-1:0] A_REF  = ADDR_W'(ADDR_REFRESH);
   localparam logic [ADDR_W-1:0] A_STRT = ADDR_W'(ADDR_START);

   logic sel_ref, sel_mode, armed_q, mode_q, mode_eff;

   assign sel_ref  = bus_we && (bus_addr == A_REF);
   assign sel_mode = bus_we && (bus_addr == A_MODE);

   // Key state: armed only after a 00h write while running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed_q <= 1'b0;
      else if (sel_ref)    armed_q <= running_i && (bus_wdata == KEY_ARM);
      else if (!running_i) armed_q <= 1'b0;
   end

   // Sticky selection bit: set-only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else if (cs_force_i || (sel_mode && wp_en_i && bus_wdata[MODE_BIT]))
         mode_q <= 1'b1;
   end

   assign mode_eff = mode_q | cs_force_i;

   always_comb begin
      ctl_o.start    = bus_we && (bus_addr == A_STRT);
      ctl_o.reload   = sel_ref && running_i && armed_q && (bus_wdata == KEY_FIRE);
      ctl_o.mode_rst = mode_eff;
      bus_rdata      = '0;
      if (bus_addr == A_MODE) bus_rdata[MODE_BIT] = mode_eff;
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wdog_ctl_t        ctl_i,
   input  logic [CNT_W-1:0] reload_val_i,
   output logic             running_o,
   output logic             irq_o,
   output logic             rst_trig_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, irq_q, trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         irq_q  <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         irq_q  <= 1'b0;
         trig_q <= 1'b0;
         if (ctl_i.start) begin
            run_q <= 1'b1;
            cnt_q <= reload_val_i;
         end else if (run_q) begin
            if (ctl_i.reload) begin
               cnt_q <= reload_val_i;
            end else if (cnt_q == '0) begin
               if (ctl_i.mode_rst) begin
                  trig_q <= 1'b1;
                  run_q  <= 1'b0;
               end else begin
                  irq_q <= 1'b1;
                  cnt_q <= reload_val_i;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign running_o  = run_q;
   assign irq_o      = irq_q;
   assign rst_trig_o = trig_q;
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
   parameter int unsigned RST_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic rst_o
);
   localparam int unsigned LEN_W = $clog2(RST_CYC + 1);

   generate
      if (RST_CYC == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= trig_i;
         end
         assign rst_o = q;
      end else begin : g_stretch
         logic [LEN_W-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            left_q <= '0;
            else if (trig_i)       left_q <= LEN_W'(RST_CYC);
            else if (left_q != '0) left_q <= left_q - 1'b1;
         end
         assign rst_o = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned MODE_BIT     = 3,
   parameter int unsigned RST_CYC      = 4,
   parameter int unsigned ADDR_MODE    = 0,
   parameter int unsigned ADDR_REFRESH = 1,
   parameter int unsigned ADDR_START   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              wp_en_i,
   input  logic              cs_force_i,
   input  logic [CNT_W-1:0]  opt_reload_i,
   output logic              wdt_irq_o,
   output logic              wdt_rst_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("wdog_ctrl: CNT_W out of range");
      end
      if (MODE_BIT >= BUS_W) begin : g_bad_bit
         $error("wdog_ctrl: MODE_BIT outside the data byte");
      end
      if (RST_CYC < 1) begin : g_bad_rst
         $error("wdog_ctrl: RST_CYC must be at least 1");
      end
      if (ADDR_MODE == ADDR_REFRESH || ADDR_MODE == ADDR_START || ADDR_REFRESH == ADDR_START
          || ADDR_START >= (1 << ADDR_W) || ADDR_MODE >= (1 << ADDR_W)
          || ADDR_REFRESH >= (1 << ADDR_W)) begin : g_bad_map
         $error("wdog_ctrl: register addresses overlap or do not fit");
      end
   endgenerate

   wdog_ctl_t ctl;
   logic      running, rst_trig, mode_eff;

   wdog_regif #(
      .ADDR_W(ADDR_W), .MODE_BIT(MODE_BIT), .ADDR_MODE(ADDR_MODE),
      .ADDR_REFRESH(ADDR_REFRESH), .ADDR_START(ADDR_START)
   ) u_regif (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .wp_en_i(wp_en_i), .cs_force_i(cs_force_i),
      .running_i(running), .ctl_o(ctl), .bus_rdata(bus_rdata)
   );

   assign mode_eff = ctl.mode_rst;

   wdog_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .reload_val_i(opt_reload_i),
      .running_o(running), .irq_o(wdt_irq_o), .rst_trig_o(rst_trig)
   );

   wdog_rstgen #(.RST_CYC(RST_CYC)) u_rstgen (
      .clk(clk), .rst_n(rst_n), .trig_i(rst_trig), .rst_o(wdt_rst_o)
   );
endmodule

module wdog_ctrl_chk #(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned ADDR_MODE = 0,
   parameter int unsigned RST_CYC   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wp_en_i,
   input logic              cs_force_i,
   input logic              mode_eff,
   input logic              wdt_irq_o,
   input logic              wdt_rst_o
);
   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_len <= '0;
      else if (wdt_rst_o) hi_len <= hi_len + 1'b1;
      else                hi_len <= '0;
   end

   p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_eff |=> mode_eff);

   p_protect_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(ADDR_MODE) && !wp_en_i && !cs_force_i && !mode_eff)
      |=> (!mode_eff || cs_force_i));

   p_force_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_force_i |-> mode_eff);

   p_rst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_o) |-> (hi_len == 16'(RST_CYC)));

   p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_irq_o |=> !wdt_irq_o);

   p_irq_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_irq_o |-> !$past(mode_eff));

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wdt_irq_o && wdt_rst_o));
endmodule

bind wdog_ctrl wdog_ctrl_chk #(
   .ADDR_W(ADDR_W), .ADDR_MODE(ADDR_MODE), .RST_CYC(RST_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .wp_en_i(wp_en_i), .cs_force_i(cs_force_i), .mode_eff(mode_eff),
   .wdt_irq_o(wdt_irq_o), .wdt_rst_o(wdt_rst_o)
);

// File: tb/wdog_ctrl_bench.sv
module wdog_ctrl_bench;
   localparam int R   = 10;
   localparam int RST = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       wp_en_i = 1'b0;
   logic       cs_force_i = 1'b0;
   logic [7:0] opt_reload_i = 8'(R);
   logic       wdt_irq_o, wdt_rst_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   int    q_kind[$];
   int    q_cyc[$];
   string q_tag[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_ctrl #(.CNT_W(8), .RST_CYC(RST)) u_wdog_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_en_i(wp_en_i),
      .cs_force_i(cs_force_i), .opt_reload_i(opt_reload_i),
      .wdt_irq_o(wdt_irq_o), .wdt_rst_o(wdt_rst_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // kind 0 = interrupt pulse, 1 = reset pulse rise
   task automatic expect_ev(input int kind, input int at, input string tag);
      q_kind.push_back(kind);
      q_cyc.push_back(at);
      q_tag.push_back(tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1;
      e = cyc;
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, int'(bus_rdata), exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_empty();
      wait (q_kind.size() == 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wp_en_i = 1'b0;
      cs_force_i = 1'b0;
      idle(3);
      rst_n = 1'b1;
   endtask

   // Monitor: compares observed pulses against the scoreboard queue
   logic rst_prev = 1'b0;
   int   hi = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (wdt_irq_o) handle(0);
         if (wdt_rst_o && !rst_prev) handle(1);
         if (wdt_rst_o) hi++;
         if (!wdt_rst_o && rst_prev) begin
            chk("R9 reset pulse length", hi, RST);
            hi = 0;
         end
         rst_prev = wdt_rst_o;
      end else begin
         rst_prev = 1'b0;
         hi = 0;
      end
   end

   task automatic handle(input int kind);
      if (q_kind.size() == 0) begin
         checks++; errors++;
         $display("FAIL R5/R9 unexpected event kind %0d at cycle %0d: actual event expected none",
                  kind, cyc);
      end else begin
         string t;
         int k, c;
         k = q_kind.pop_front();
         c = q_cyc.pop_front();
         t = q_tag.pop_front();
         chk({t, " event kind"}, kind, k);
         chk({t, " event cycle"}, cyc, c);
      end
   endtask

   initial begin
      int e, nxt;
      do_reset();
      // R1: reset state
      rd_chk(2'd0, 0, "R1 mode read after reset");
      chk("R1 irq low", int'(wdt_irq_o), 0);
      chk("R1 rst low", int'(wdt_rst_o), 0);
      idle(30);
      // R5: refresh while stopped
      wr(2'd1, 8'h00, e);
      wr(2'd1, 8'hFF, e);
      idle(30);
      // R7: protected writes blocked
      wp_en_i = 1'b0;
      wr(2'd0, 8'h08, e);
      rd_chk(2'd0, 0, "R7 mode write without protect enable");
      // R6: set-only bit, reserved bits zero
      wp_en_i = 1'b1;
      wr(2'd0, 8'hF7, e);
      rd_chk(2'd0, 0, "R6 reserved bits read zero");
      wr(2'd0, 8'h08, e);
      rd_chk(2'd0, 8'h08, "R6 mode bit set");
      wr(2'd0, 8'h00, e);
      rd_chk(2'd0, 8'h08, "R6 mode bit not cleared by 0");
      wp_en_i = 1'b0;
      // R9: reset mode underflow, then stop
      wr(2'd2, 8'h5A, e);
      expect_ev(1, e + R + 2, "R9 reset underflow");
      wait_empty();
      idle(40);
      wr(2'd2, 8'h00, e);
      expect_ev(1, e + R + 2, "R9 restart after reset");
      wait_empty();
      idle(10);

      do_reset();
      rd_chk(2'd0, 0, "R1 mode read after second reset");
      // R2: start and periodic interrupts
      wr(2'd2, 8'h00, e);
      expect_ev(0, e + R + 1, "R2 first interrupt");
      expect_ev(0, e + 2 * (R + 1), "R2 periodic interrupt");
      wait_empty();
      // R3: clean key
      wr(2'd1, 8'h00, e);
      wr(2'd1, 8'hFF, e);
      nxt = e + R + 1;
      expect_ev(0, nxt, "R3 refresh 00-FF reload");
      wait_empty();
      // R4: lone FF
      wr(2'd1, 8'hFF, e);
      nxt = nxt + R + 1;
      expect_ev(0, nxt, "R4 lone FF ignored");
      wait_empty();
      // R4: broken key
      wr(2'd1, 8'h00, e);
      wr(2'd1, 8'h5A, e);
      wr(2'd1, 8'hFF, e);
      nxt = nxt + R + 1;
      expect_ev(0, nxt, "R4 00-5A-FF ignored");
      wait_empty();
      // R3: doubled 00
      wr(2'd1, 8'h00, e);
      wr(2'd1, 8'h00, e);
      wr(2'd1, 8'hFF, e);
      expect_ev(0, e + R + 1, "R3 refresh 00-00-FF reload");
      wait_empty();
      // R2: restart while running with other data
      wr(2'd2, 8'hA5, e);
      nxt = e + R + 1;
      expect_ev(0, nxt, "R2 restart with A5h");
      wait_empty();
      // R8: forced mode
      cs_force_i = 1'b1;
      rd_chk(2'd0, 8'h08, "R8 forced mode bit");
      expect_ev(1, nxt + R + 2, "R8 forced reset mode underflow");
      cs_force_i = 1'b0;
      rd_chk(2'd0, 8'h08, "R8 mode bit stays after force drops");
      wait_empty();
      idle(30);

      while (q_kind.size() > 0) begin
         string t;
         void'(q_kind.pop_front());
         void'(q_cyc.pop_front());
         t = q_tag.pop_front();
         checks++; errors++;
         $display("FAIL %s: actual no event expected event", t);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule